// File: doc/BRIEF.md
# Tracking Brake Direction Gate

This block sits between the tracking equalizer and the tracking actuator driver. While the tracking loop is being pulled in, during setup or at the end of a track jump, the lens is still crossing tracks. The loop closes more easily if the actuator only receives drive that slows the lens down. The gate works out which way the lens is moving. It then passes only the equalizer samples whose sign opposes that motion. Samples of the other sign are replaced by zero.

The sign of the tracking-crossing signal is turned into a clean zero-cross level by a small state machine with hysteresis. On each rising or falling zero-cross edge, the synchronized mirror signal (on-track/off-track) is captured. The captured value, together with the kind of edge it was captured on, gives the direction of motion. A second state machine then decides whether the drive is passed through unchanged, held at zero, or gated for forward or reverse braking. In normal play the enable input is low and the drive passes through untouched.

Top module: `trk_brake_gate`

## Requirements
- R1: After reset the gate is in the pass-through state, `dir_fwd` is 0 and the zero-cross level is negative.
- R2: While `brake_en` was low at the previous rising clock edge, `drv_out` equals `eq_drive`, sample for sample.
- R3: The zero-cross level changes only after `HYST_LEN` consecutive clock samples (default 2) of the new `tec_pos` value. A single-sample excursion produces no zero-cross edge.
- R4: `mirr_in` passes through a two-stage synchronizer. On each zero-cross edge, the synchronized value is captured. A rising edge with mirror 1, or a falling edge with mirror 0, sets `dir_fwd` to 1 (forward, inner to outer). The other two cases set it to 0 (reverse).
- R5: `dir_fwd` changes only on zero-cross edges. It keeps being updated while the gate is bypassed.
- R6: When `brake_en` rises, the gate enters an armed state. In that state `drv_out` is zero until the first direction capture after arming.
- R7: In forward braking, negative `eq_drive` samples (including the most negative code) pass unchanged. Zero and positive samples give 0.
- R8: In reverse braking, positive `eq_drive` samples pass unchanged. Zero and negative samples give 0.
- R9: Timing with the default parameters:
  - `tec_pos` changes and is held; call the first rising clock edge that samples the new value e0.
  - `dir_fwd` shows the new direction after edge e2.
  - The gate state, and so the polarity rule applied to `drv_out`, follows `dir_fwd` one edge later, after e3.
- R10: Dropping `brake_en` returns the gate to pass-through at the next rising clock edge. Before that edge the previous gating still applies.
- R11: `drv_out` is always either zero or exactly `eq_drive`.

Gate states and transitions:
- **BYPASS**
  - goes to ARMED when `brake_en` is high.
- **ARMED**
  - goes to FWD or REV on a direction capture, chosen by the captured direction.
- **FWD**
  - goes to REV when `dir_fwd` is 0.
- **REV**
  - goes to FWD when `dir_fwd` is 1.
- Any state goes to BYPASS when `brake_en` is low.

Zero-cross states and transitions:
- **NEG**
  - goes to NEG_PEND when a positive sample arrives.
- **NEG_PEND**
  - goes back to NEG when a negative sample arrives.
  - goes to POS once the count of positive samples reaches `HYST_LEN`; this emits a rising edge pulse.
- **POS** and **POS_PEND**
  - mirror NEG and NEG_PEND, with the signs swapped; the completed count emits a falling edge pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tec_pos | input | 1 | Sign of the tracking-crossing signal, 1 = positive |
| mirr_in | input | 1 | Mirror (on-track/off-track) signal, asynchronous |
| eq_drive | input | DW | Signed two's-complement tracking equalizer sample |
| brake_en | input | 1 | High during setup and jump capture; low in normal play |
| drv_out | output | DW | Signed drive to the actuator, gated or passed through |
| dir_fwd | output | 1 | Detected direction: 1 forward, 0 reverse |

## Verification
The gated drive is a combinational function of the gate state and `eq_drive`, so its value changes as soon as the input does. A new gating rule takes effect exactly one edge after a change of `brake_en` or `dir_fwd`. A held sign change of `tec_pos` reaches `dir_fwd` after the third rising edge and the gate state after the fourth. The bench drives inputs on falling edges and samples on falling edges a counted number of cycles later. This lets it check the cycle before and the cycle of each change. The table-driven part holds each vector for eight cycles, so every path has settled before the compare.

// File: rtl/trk_brake_pkg.sv
package trk_brake_pkg;

    // Zero-cross squarer states: level plus a pending-flip variant
    typedef enum logic [1:0] {
        ZC_NEG      = 2'd0,
        ZC_NEG_PEND = 2'd1,
        ZC_POS      = 2'd2,
        ZC_POS_PEND = 2'd3
    } zc_state_e;

    // Drive gate states
    typedef enum logic [1:0] {
        GATE_BYPASS = 2'd0,
        GATE_ARMED  = 2'd1,
        GATE_FWD    = 2'd2,
        GATE_REV    = 2'd3
    } gate_state_e;

endpackage

// File: rtl/tbg_mirr_sync.sv
module tbg_mirr_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] chain_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[TOP-1:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[TOP];
endmodule

// File: rtl/tbg_zc_squarer.sv
module tbg_zc_squarer
    import trk_brake_pkg::*;
#(
    parameter int HYST_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tec_pos,
    output logic zc_rise,
    output logic zc_fall
);
    localparam int CW = (HYST_LEN < 2) ? 1 : $clog2(HYST_LEN);
    localparam logic [CW-1:0] LIM = CW'(HYST_LEN - 1);
    localparam logic [CW-1:0] ONE = CW'(1);

    zc_state_e     zc_q, zc_n;
    logic [CW-1:0] cnt_q, cnt_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zc_q  <= ZC_NEG;
            cnt_q <= '0;
        end else begin
            zc_q  <= zc_n;
            cnt_q <= cnt_n;
        end
    end

    // Next-state logic with hysteresis count
    always_comb begin
        zc_n  = zc_q;
        cnt_n = cnt_q;
        unique case (zc_q)
            ZC_NEG: begin
                if (tec_pos) begin
                    if (HYST_LEN < 2) begin
                        zc_n  = ZC_POS;
                        cnt_n = '0;
                    end else begin
                        zc_n  = ZC_NEG_PEND;
                        cnt_n = ONE;
                    end
                end
            end
            ZC_NEG_PEND: begin
                if (!tec_pos) begin
                    zc_n  = ZC_NEG;
                    cnt_n = '0;
                end else if (cnt_q == LIM) begin
                    zc_n  = ZC_POS;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q + ONE;
                end
            end
            ZC_POS: begin
                if (!tec_pos) begin
                    if (HYST_LEN < 2) begin
                        zc_n  = ZC_NEG;
                        cnt_n = '0;
                    end else begin
                        zc_n  = ZC_POS_PEND;
                        cnt_n = ONE;
                    end
                end
            end
            ZC_POS_PEND: begin
                if (tec_pos) begin
                    zc_n  = ZC_POS;
                    cnt_n = '0;
                end else if (cnt_q == LIM) begin
                    zc_n  = ZC_NEG;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q + ONE;
                end
            end
            default: begin
                zc_n  = ZC_NEG;
                cnt_n = '0;
            end
        endcase
    end

    // Registered edge pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zc_rise <= 1'b0;
            zc_fall <= 1'b0;
        end else begin
            zc_rise <= (zc_n == ZC_POS) &&
                       ((zc_q == ZC_NEG) || (zc_q == ZC_NEG_PEND));
            zc_fall <= (zc_n == ZC_NEG) &&
                       ((zc_q == ZC_POS) || (zc_q == ZC_POS_PEND));
        end
    end
endmodule

// File: rtl/tbg_dir_latch.sv
module tbg_dir_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic zc_rise,
    input  logic zc_fall,
    input  logic mirr_s,
    output logic dir_q,
    output logic dir_upd
);
    // Switching pulse: mirror captured at each zero-cross edge,
    // interpreted against the edge polarity.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= 1'b0;
            dir_upd <= 1'b0;
        end else begin
            dir_upd <= zc_rise | zc_fall;
            if (zc_rise)      dir_q <= mirr_s;
            else if (zc_fall) dir_q <= ~mirr_s;
        end
    end
endmodule

// File: rtl/trk_brake_gate.sv
module trk_brake_gate
    import trk_brake_pkg::*;
#(
    parameter int DW          = 16,
    parameter int HYST_LEN    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tec_pos,
    input  logic                 mirr_in,
    input  logic signed [DW-1:0] eq_drive,
    input  logic                 brake_en,
    output logic signed [DW-1:0] drv_out,
    output logic                 dir_fwd
);
    localparam logic signed [DW-1:0] ZERO = '0;

    logic        mirr_s;
    logic        zc_rise, zc_fall;
    logic        dir_upd;
    gate_state_e gate_q, gate_n;

    tbg_mirr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mirr_in),
        .sync_out (mirr_s)
    );

    tbg_zc_squarer #(.HYST_LEN(HYST_LEN)) u_zc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tec_pos (tec_pos),
        .zc_rise (zc_rise),
        .zc_fall (zc_fall)
    );

    tbg_dir_latch u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .zc_rise (zc_rise),
        .zc_fall (zc_fall),
        .mirr_s  (mirr_s),
        .dir_q   (dir_fwd),
        .dir_upd (dir_upd)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= GATE_BYPASS;
        else        gate_q <= gate_n;
    end

    // Next-state logic
    always_comb begin
        gate_n = gate_q;
        if (!brake_en) begin
            gate_n = GATE_BYPASS;
        end else begin
            unique case (gate_q)
                GATE_BYPASS: gate_n = GATE_ARMED;
                GATE_ARMED:  if (dir_upd) gate_n = dir_fwd ? GATE_FWD : GATE_REV;
                GATE_FWD:    if (!dir_fwd) gate_n = GATE_REV;
                GATE_REV:    if (dir_fwd)  gate_n = GATE_FWD;
                default:     gate_n = GATE_BYPASS;
            endcase
        end
    end

    // Output logic: pass, block, or pass one polarity only
    always_comb begin
        drv_out = ZERO;
        unique case (gate_q)
            GATE_BYPASS: drv_out = eq_drive;
            GATE_ARMED:  drv_out = ZERO;
            GATE_FWD:    drv_out = (eq_drive < ZERO) ? eq_drive : ZERO;
            GATE_REV:    drv_out = (eq_drive > ZERO) ? eq_drive : ZERO;
            default:     drv_out = ZERO;
        endcase
    end
endmodule

// File: rtl/trk_brake_gate_chk.sv
module trk_brake_gate_chk #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tec_pos,
    input logic                 brake_en,
    input logic signed [DW-1:0] eq_drive,
    input logic signed [DW-1:0] drv_out,
    input logic                 dir_fwd,
    input logic                 zc_rise,
    input logic                 zc_fall
);
    localparam logic signed [DW-1:0] ZERO = '0;

    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    assert_out_choice_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_out == ZERO) || (drv_out == eq_drive));

    assert_bypass_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && !$past(brake_en) |-> drv_out == eq_drive);

    assert_fwd_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(brake_en) && $past(dir_fwd) && (drv_out != ZERO) |-> drv_out < ZERO);

    assert_rev_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(brake_en) && !$past(dir_fwd) && (drv_out != ZERO) |-> drv_out > ZERO);

    assert_rise_hyst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        zc_rise |-> $past(tec_pos) && $past(tec_pos, 2));

    assert_fall_hyst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        zc_fall |-> !$past(tec_pos) && !$past(tec_pos, 2));

    assert_edge_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({zc_rise, zc_fall}));

    assert_dir_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && !$stable(dir_fwd) |-> $past(zc_rise) || $past(zc_fall));
endmodule

bind trk_brake_gate trk_brake_gate_chk #(.DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tec_pos  (tec_pos),
    .brake_en (brake_en),
    .eq_drive (eq_drive),
    .drv_out  (drv_out),
    .dir_fwd  (dir_fwd),
    .zc_rise  (zc_rise),
    .zc_fall  (zc_fall)
);

// File: tb/trk_brake_gate_tb_top.sv
module trk_brake_gate_tb_top;
    localparam int DW = 16;
    localparam time HALF = 2ns;   // 250 MHz

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 tec_pos = 1'b0;
    logic                 mirr_in = 1'b0;
    logic signed [DW-1:0] eq_drive = '0;
    logic                 brake_en = 1'b0;
    logic signed [DW-1:0] drv_out;
    logic                 dir_fwd;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #HALF clk = ~clk;

    trk_brake_gate #(.DW(DW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tec_pos  (tec_pos),
        .mirr_in  (mirr_in),
        .eq_drive (eq_drive),
        .brake_en (brake_en),
        .drv_out  (drv_out),
        .dir_fwd  (dir_fwd)
    );

    typedef struct packed {
        logic                 en;
        logic                 tec;
        logic                 mirr;
        logic signed [DW-1:0] eq;
        logic signed [DW-1:0] exp_drv;
        logic                 exp_dir;
        logic [3:0]           req;
    } vec_t;

    // Each vector is held 8 cycles, then drv_out and dir_fwd are compared.
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0,  16'sd100,  16'sd100, 1'b0, 4'd2},  // R2 pass positive
        '{1'b0, 1'b0, 1'b0, -16'sd50,  -16'sd50,  1'b0, 4'd2},  // R2 pass negative
        '{1'b1, 1'b0, 1'b1,  16'sd100,  16'sd0,   1'b0, 4'd6},  // R6 armed, no edge
        '{1'b1, 1'b1, 1'b1, -16'sd80,  -16'sd80,  1'b1, 4'd7},  // R7 rise, mirr 1 -> fwd
        '{1'b1, 1'b1, 1'b1,  16'sd80,   16'sd0,   1'b1, 4'd7},  // R7 fwd blocks positive
        '{1'b1, 1'b0, 1'b0,  16'sd80,   16'sd0,   1'b1, 4'd4},  // R4 fall, mirr 0 -> fwd
        '{1'b1, 1'b1, 1'b0,  16'sd80,   16'sd80,  1'b0, 4'd8},  // R8 rise, mirr 0 -> rev
        '{1'b1, 1'b1, 1'b0, -16'sd80,   16'sd0,   1'b0, 4'd8},  // R8 rev blocks negative
        '{1'b1, 1'b0, 1'b1, -16'sd80,   16'sd0,   1'b0, 4'd4},  // R4 fall, mirr 1 -> rev
        '{1'b1, 1'b0, 1'b1,  16'sd0,    16'sd0,   1'b0, 4'd8},  // R8 zero gives zero
        '{1'b0, 1'b0, 1'b1, -16'sd80,  -16'sd80,  1'b0, 4'd2},  // R2 bypass again
        '{1'b1, 1'b0, 1'b1,  16'sd77,   16'sd0,   1'b0, 4'd6}   // R6 re-armed blocks
    };

    task automatic chk_drv(input string tag, input logic signed [DW-1:0] exp);
        n_cmp++;
        if (drv_out !== exp) begin
            n_bad++;
            $display("FAIL %s drv_out actual %0d expected %0d", tag, drv_out, exp);
        end
    endtask

    task automatic chk_dir(input string tag, input logic exp);
        n_cmp++;
        if (dir_fwd !== exp) begin
            n_bad++;
            $display("FAIL %s dir_fwd actual %0b expected %0b", tag, dir_fwd, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(HALF * 2 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        eq_drive = 16'sd33;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
        chk_drv("R1 reset pass-through", 16'sd33);
        chk_dir("R1 reset direction", 1'b0);

        foreach (VECS[i]) begin
            brake_en = VECS[i].en;
            tec_pos  = VECS[i].tec;
            mirr_in  = VECS[i].mirr;
            eq_drive = VECS[i].eq;
            wait_neg(8);
            chk_drv($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp_drv);
            chk_dir($sformatf("R%0d vector %0d dir", VECS[i].req, i), VECS[i].exp_dir);
        end

        // R3: one-sample excursion of the crossing sign makes no edge (still armed)
        eq_drive = -16'sd5;
        tec_pos = 1'b1;
        wait_neg(1);
        tec_pos = 1'b0;
        wait_neg(8);
        chk_drv("R3 glitch keeps armed", 16'sd0);
        chk_dir("R3 glitch keeps direction", 1'b0);

        // R9: exact latency of a held rising crossing with mirror 1
        tec_pos = 1'b1;
        wait_neg(3);
        chk_dir("R9 direction after third edge", 1'b1);
        chk_drv("R9 gate not yet switched", 16'sd0);
        wait_neg(1);
        chk_drv("R9 gate switched after fourth edge", -16'sd5);

        // R7: most negative code passes in forward braking
        eq_drive = 16'sh8000;
        wait_neg(1);
        chk_drv("R7 most negative passes", 16'sh8000);
        eq_drive = 16'sh7fff;
        wait_neg(1);
        chk_drv("R7 most positive blocked", 16'sd0);

        // R10: disable takes effect at the next edge, not before
        eq_drive = 16'sd200;
        brake_en = 1'b0;
        #1;
        chk_drv("R10 before edge still gated", 16'sd0);
        wait_neg(1);
        chk_drv("R10 after edge pass-through", 16'sd200);

        // R5: direction keeps tracking in bypass (fall with mirror 1 -> reverse)
        tec_pos = 1'b0;
        wait_neg(8);
        chk_dir("R5 direction updated in bypass", 1'b0);
        chk_drv("R2 bypass during update", 16'sd200);

        // R8: most negative code blocked in reverse braking
        brake_en = 1'b1;
        tec_pos = 1'b1;
        mirr_in = 1'b0;
        eq_drive = 16'sh8000;
        wait_neg(10);
        chk_dir("R4 rise with mirror 0 reverse", 1'b0);
        chk_drv("R8 most negative blocked", 16'sd0);
        eq_drive = 16'sd1;
        wait_neg(1);
        chk_drv("R8 smallest positive passes", 16'sd1);
        chk_drv("R11 output is input or zero", eq_drive);

        finish_run();
    end
endmodule